// File: doc/BRIEF.md
# Two-Event Classification Tracker

This block follows the supply voltage of a powered device as it climbs through the detection, classification, mark and operating ranges. The voltage is not measured here. It arrives as four single-bit comparator results: above the lower class threshold, above the upper class threshold, below the mark-reset level, and under-voltage lockout released. From these inputs the block decides whether the power source ran a two-step hardware classification, that is a class pulse, a drop back to a mark, and a second class pulse. It holds that decision until the voltage falls low enough to clear it.

The block drives three enables for the analog front end: the detection signature, the mark signature and the classification current source. It also drives an active-low "high-power source" indicator. The indicator combines the latched decision with an external-adapter flag, and is suppressed during thermal shutdown and while the pass switch is limiting inrush. Every input passes through a synchronizer of configurable depth. A flag combination that no real voltage could produce is ignored, and the block keeps its current state.

Top module: `tpc_tracker`

## Requirements
- R1: While the synchronous reset is asserted and afterwards, with the voltage flags reading "below mark reset" (only `below_mark_rst`=1), the outputs are: detection enable 1, class and mark enables 0, type-2 flag 0, `t2_ind_n` 1.
- R2: With no mark seen since the last mark reset, the detection signature enable is 1 whenever the voltage is below the lower class threshold (`above_cls_lo`=0). It is 0 above that threshold.
- R3: The class current enable is 1 only in the class range (`above_cls_lo`=1, `above_cls_hi`=0). It is 0 at or above the upper threshold and below the lower one.
- R4: Inside the class range, any of `over_temp`, `adapter_det` or `disable_req` forces the class current enable to 0.
- R5: A fall from the class range into the detection range (`above_cls_lo`=0, `below_mark_rst`=0) is a mark event. From then on, the mark enable is 1 and the detection enable is 0 whenever the voltage is in the detection range. This continues until a fall below the mark-reset level.
- R6: `type2_seen` becomes 1 when the voltage rises above the upper class threshold straight from a second class range that came after class, mark, class. A single class pulse followed by a rise leaves it at 0.
- R7: If the path is broken, a later rise does not set `type2_seen` until a mark reset has occurred. A break is a fall from the second class range back into the mark range, or a return from above the upper threshold into the class range. A full class, mark, class, rise sequence after the mark reset sets it again.
- R8: Once set, `type2_seen` stays 1 through every range change, including a drop out of the operating range. It is cleared only by a fall below the mark-reset level.
- R9: `t2_ind_n` is 0 exactly when (`type2_seen` or `adapter_det`) is 1, and `inrush_on` and `over_temp` are both 0. Otherwise it is 1.
- R10: Flag combinations that no voltage can produce change no state. These are: upper set without lower, lower set together with below-mark-reset, and lockout released without upper. The enables and `type2_seen` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_cls_lo | input | 1 | Voltage above lower class threshold |
| above_cls_hi | input | 1 | Voltage above upper class threshold |
| below_mark_rst | input | 1 | Voltage below mark-reset level |
| uvlo_ok | input | 1 | Under-voltage lockout released (operating range) |
| over_temp | input | 1 | Thermal shutdown active |
| adapter_det | input | 1 | External adapter detected |
| disable_req | input | 1 | External disable of the class source |
| inrush_on | input | 1 | Pass switch is in inrush limiting |
| det_sig_en | output | 1 | Detection signature enable |
| cls_src_en | output | 1 | Classification current source enable |
| mark_sig_en | output | 1 | Mark signature enable |
| type2_seen | output | 1 | Latched two-event classification result |
| t2_ind_n | output | 1 | Active-low high-power source indicator |

## Verification
The latch of the type-2 decision and the inrush gating of the indicator can fall in the same cycle. The bench provokes this by raising the voltage above the upper threshold from the second class range on the same clock edge that `inrush_on` rises. The result is judged correct when `type2_seen` reads 1 while `t2_ind_n` stays 1, and `t2_ind_n` then falls to 0 as soon as inrush ends. The mark event and the path break are also exercised back to back, by taking a second fall out of the second class range and showing that the next rise leaves the flag clear.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DETECT    = 3'd1,
        ST_CLASS1    = 3'd2,
        ST_MARK      = 3'd3,
        ST_CLASS2    = 3'd4,
        ST_BETWEEN   = 3'd5,
        ST_OPERATING = 3'd6
    } trk_state_e;

    typedef enum logic [2:0] {
        RG_RESET   = 3'd0,
        RG_DETECT  = 3'd1,
        RG_CLASS   = 3'd2,
        RG_UPPER   = 3'd3,
        RG_POWERED = 3'd4,
        RG_ILLEGAL = 3'd5
    } v_region_e;

    typedef struct packed {
        logic cl_lo;
        logic cl_hi;
        logic mrst;
        logic uvlo;
    } vflags_t;

    typedef struct packed {
        logic ot;
        logic adp;
        logic dis;
        logic inrush;
    } ctl_t;

    localparam int VFLAG_W = $bits(vflags_t);
    localparam int CTL_W   = $bits(ctl_t);

    // Map comparator flags onto a voltage region; impossible sets map to RG_ILLEGAL.
    function automatic v_region_e decode_region(input vflags_t f);
        v_region_e r;
        if ((f.cl_hi && !f.cl_lo) || (f.mrst && f.cl_lo) || (f.uvlo && !f.cl_hi))
            r = RG_ILLEGAL;
        else if (f.uvlo)
            r = RG_POWERED;
        else if (f.cl_hi)
            r = RG_UPPER;
        else if (f.cl_lo)
            r = RG_CLASS;
        else if (f.mrst)
            r = RG_RESET;
        else
            r = RG_DETECT;
        return r;
    endfunction

    function automatic logic in_class(input trk_state_e s);
        return (s == ST_CLASS1) || (s == ST_CLASS2);
    endfunction

endpackage

// File: rtl/tpc_sync.sv
module tpc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tpc_fsm.sv
module tpc_fsm
    import tpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  v_region_e  region,
    output trk_state_e state,
    output logic       type2,
    output logic       marked
);
    trk_state_e st_q, st_d;
    logic       path_q, path_d;
    logic       mark_q, mark_d;
    logic       t2_q, t2_d;

    always_comb begin
        st_d   = st_q;
        path_d = path_q;
        mark_d = mark_q;
        t2_d   = t2_q;
        case (region)
            RG_RESET: begin
                st_d   = ST_IDLE;
                path_d = 1'b0;
                mark_d = 1'b0;
                t2_d   = 1'b0;
            end
            RG_DETECT: begin
                case (st_q)
                    ST_CLASS1: begin
                        st_d   = ST_MARK;
                        mark_d = 1'b1;
                    end
                    ST_CLASS2: begin
                        st_d   = ST_MARK;
                        mark_d = 1'b1;
                        path_d = 1'b0;
                    end
                    ST_MARK: ;
                    default: begin
                        st_d   = mark_q ? ST_MARK : ST_DETECT;
                        path_d = 1'b0;
                    end
                endcase
            end
            RG_CLASS: begin
                case (st_q)
                    ST_IDLE, ST_DETECT: begin
                        st_d   = ST_CLASS1;
                        path_d = !mark_q;
                    end
                    ST_MARK: st_d = path_q ? ST_CLASS2 : ST_CLASS1;
                    ST_CLASS1, ST_CLASS2: ;
                    default: begin
                        st_d   = ST_CLASS1;
                        path_d = 1'b0;
                    end
                endcase
            end
            RG_UPPER, RG_POWERED: begin
                if (st_q == ST_CLASS2 && path_q) t2_d = 1'b1;
                path_d = 1'b0;
                st_d   = (region == RG_UPPER) ? ST_BETWEEN : ST_OPERATING;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            path_q <= 1'b0;
            mark_q <= 1'b0;
            t2_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            path_q <= path_d;
            mark_q <= mark_d;
            t2_q   <= t2_d;
        end
    end

    assign state  = st_q;
    assign type2  = t2_q;
    assign marked = mark_q;

    AST_T2_SET_FROM_CLASS2: assert property (@(posedge clk) disable iff (rst)
        $rose(t2_q) |-> $past(st_q == ST_CLASS2 && path_q)); // R6
    AST_T2_CLEAR_BY_MRST: assert property (@(posedge clk) disable iff (rst)
        $fell(t2_q) |-> $past(region == RG_RESET)); // R8
    AST_MARK_FROM_CLASS: assert property (@(posedge clk) disable iff (rst)
        $rose(mark_q) |-> $past(in_class(st_q))); // R5
    AST_MARK_NO_DETECT: assert property (@(posedge clk) disable iff (rst)
        mark_q |-> (st_q != ST_DETECT)); // R5
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (region == RG_ILLEGAL) |=> ($stable(st_q) && $stable(t2_q))); // R10
endmodule

// File: rtl/tpc_outputs.sv
module tpc_outputs
    import tpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trk_state_e state,
    input  logic       type2,
    input  ctl_t       ctl,
    output logic       det_en,
    output logic       cls_en,
    output logic       mark_en,
    output logic       ind_n
);
    logic cls_block;
    logic ind_gate;

    assign cls_block = ctl.ot | ctl.adp | ctl.dis;
    assign ind_gate  = !ctl.inrush && !ctl.ot;

    always_comb begin
        det_en  = (state == ST_IDLE) || (state == ST_DETECT);
        mark_en = (state == ST_MARK);
        cls_en  = in_class(state) && !cls_block;
        ind_n   = !((type2 || ctl.adp) && ind_gate);
    end

    AST_SIG_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({det_en, mark_en, cls_en})); // R3
    AST_IND_QUIET_IN_INRUSH: assert property (@(posedge clk) disable iff (rst)
        (ctl.inrush && !type2 && !ctl.adp) |-> ind_n); // R9
endmodule

// File: rtl/tpc_tracker.sv
module tpc_tracker
    import tpc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic above_cls_lo,
    input  logic above_cls_hi,
    input  logic below_mark_rst,
    input  logic uvlo_ok,
    input  logic over_temp,
    input  logic adapter_det,
    input  logic disable_req,
    input  logic inrush_on,
    output logic det_sig_en,
    output logic cls_src_en,
    output logic mark_sig_en,
    output logic type2_seen,
    output logic t2_ind_n
);
    vflags_t    vf_raw, vf_s;
    ctl_t       ctl_raw, ctl_s;
    v_region_e  region;
    trk_state_e state;
    logic       type2;
    logic       marked;

    assign vf_raw  = '{cl_lo: above_cls_lo, cl_hi: above_cls_hi, mrst: below_mark_rst, uvlo: uvlo_ok};
    assign ctl_raw = '{ot: over_temp, adp: adapter_det, dis: disable_req, inrush: inrush_on};

    tpc_sync #(.WIDTH(VFLAG_W), .STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst(rst), .d(vf_raw), .q(vf_s)
    );
    tpc_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_csync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
    );

    assign region = decode_region(vf_s);

    tpc_fsm u_fsm (
        .clk(clk), .rst(rst), .region(region),
        .state(state), .type2(type2), .marked(marked)
    );

    tpc_outputs u_out (
        .clk(clk), .rst(rst), .state(state), .type2(type2), .ctl(ctl_s),
        .det_en(det_sig_en), .cls_en(cls_src_en), .mark_en(mark_sig_en), .ind_n(t2_ind_n)
    );

    assign type2_seen = type2;

    AST_MARK_ONLY_WHEN_MARKED: assert property (@(posedge clk) disable iff (rst)
        mark_sig_en |-> marked); // R5
endmodule

// File: tb/tpc_tracker_tb.sv
`timescale 1ns/1ps
module tpc_tracker_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cl = 0, cu = 0, mr = 1, uv = 0;
    logic ot = 0, adp = 0, dis = 0, inr = 0;
    logic det, cls, mark, t2, ind_n;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    localparam logic [3:0] V_RST = 4'b0010;
    localparam logic [3:0] V_DET = 4'b0000;
    localparam logic [3:0] V_CLS = 4'b1000;
    localparam logic [3:0] V_UP  = 4'b1100;
    localparam logic [3:0] V_PWR = 4'b1101;
    localparam logic [3:0] V_BAD = 4'b0100;

    always #2 clk = ~clk;

    tpc_tracker dut_i (
        .clk(clk), .rst(rst),
        .above_cls_lo(cl), .above_cls_hi(cu), .below_mark_rst(mr), .uvlo_ok(uv),
        .over_temp(ot), .adapter_det(adp), .disable_req(dis), .inrush_on(inr),
        .det_sig_en(det), .cls_src_en(cls), .mark_sig_en(mark),
        .type2_seen(t2), .t2_ind_n(ind_n)
    );

    task automatic settle();
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic apply_v(input logic [3:0] v);
        @(negedge clk);
        {cl, cu, mr, uv} = v;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {cl, cu, mr, uv} = V_RST;
        {ot, adp, dis, inr} = 4'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
    endtask

    // expected vector order: det, cls, mark, type2, ind_n
    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {det, cls, mark, t2, ind_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got det/cls/mark/t2/ind_n=%b expected %b", req, act, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state, checked during and after reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 5'b10001);
        do_reset();
        chk("R1 after reset", 5'b10001);

        // R2 R3 R10 sweep of every flag combination from a fresh reset
        for (int i = 0; i < 16; i++) begin
            logic [3:0] v;
            logic [4:0] e;
            v = i[3:0];
            do_reset();
            apply_v(v);
            if (v == V_RST || v == V_DET) e = 5'b10001;
            else if (v == V_CLS)          e = 5'b01001;
            else if (v == V_UP || v == V_PWR) e = 5'b00001;
            else                          e = 5'b10001; // illegal: held in idle
            chk($sformatf("R2/R3/R10 sweep flags=%b", v), e);
        end

        // R4 gating sweep in class range, plus adapter effect on indicator (R9)
        do_reset();
        apply_v(V_DET);
        apply_v(V_CLS);
        for (int g = 0; g < 8; g++) begin
            logic [2:0] gg;
            logic e_cls, e_ind;
            gg = g[2:0];
            @(negedge clk);
            {ot, adp, dis} = gg;
            settle();
            e_cls = (gg == 3'b000);
            e_ind = !(gg[1] && !gg[2]);
            chk($sformatf("R4/R9 class gating ot/adp/dis=%b", gg), {1'b0, e_cls, 1'b0, 1'b0, e_ind});
        end
        @(negedge clk);
        {ot, adp, dis} = 3'b0;

        // R5 R6 full two-event path
        do_reset();
        apply_v(V_DET); chk("R2 detection range", 5'b10001);
        apply_v(V_CLS); chk("R3 first class", 5'b01001);
        apply_v(V_DET); chk("R5 mark event", 5'b00101);
        apply_v(V_CLS); chk("R3 second class", 5'b01001);
        apply_v(V_UP);  chk("R6 latch on rise", 5'b00010);
        apply_v(V_PWR); chk("R9 operating indicator", 5'b00010);

        // R9 indicator sweep with type2 latched
        for (int g = 0; g < 8; g++) begin
            logic [2:0] gg;
            gg = g[2:0];
            @(negedge clk);
            {ot, adp, inr} = gg;
            settle();
            chk($sformatf("R9 indicator ot/adp/inrush=%b", gg),
                {3'b000, 1'b1, !(!gg[2] && !gg[0])});
        end
        @(negedge clk);
        {ot, adp, inr} = 3'b0;
        settle();

        // R10 illegal combination after latch holds everything
        apply_v(V_BAD); chk("R10 illegal holds", 5'b00010);

        // R8 latch survives falls until mark reset
        apply_v(V_UP);  chk("R8 between range", 5'b00010);
        apply_v(V_CLS); chk("R8 back in class", 5'b01010);
        apply_v(V_DET); chk("R5 R8 mark range", 5'b00110);
        apply_v(V_RST); chk("R8 mark reset clears", 5'b10001);

        // R6 single class pulse does not latch
        do_reset();
        apply_v(V_DET);
        apply_v(V_CLS);
        apply_v(V_UP);  chk("R6 single event", 5'b00001);

        // R7 broken path: second fall out of class2
        do_reset();
        apply_v(V_DET); apply_v(V_CLS); apply_v(V_DET); apply_v(V_CLS);
        apply_v(V_DET); chk("R7 second mark", 5'b00101);
        apply_v(V_CLS);
        apply_v(V_UP);  chk("R7 broken path no latch", 5'b00001);
        // R7 return from above upper into class breaks the path too
        apply_v(V_CLS); apply_v(V_DET); apply_v(V_CLS);
        apply_v(V_UP);  chk("R7 no latch without mark reset", 5'b00001);
        // R7 new attempt after mark reset
        apply_v(V_RST); apply_v(V_DET); apply_v(V_CLS); apply_v(V_DET); apply_v(V_CLS);
        apply_v(V_UP);  chk("R7 fresh attempt latches", 5'b00010);

        // R6 R9 latch and inrush start in the same cycle
        do_reset();
        apply_v(V_DET); apply_v(V_CLS); apply_v(V_DET); apply_v(V_CLS);
        @(negedge clk);
        {cl, cu, mr, uv} = V_UP;
        inr = 1'b1;
        settle();
        chk("R6/R9 latch during inrush", 5'b00011);
        @(negedge clk);
        inr = 1'b0;
        settle();
        chk("R9 inrush ends", 5'b00010);

        // R9 adapter alone asserts, dropping it releases
        do_reset();
        @(negedge clk); adp = 1'b1; settle();
        chk("R9 adapter asserts", 5'b10000);
        @(negedge clk); adp = 1'b0; settle();
        chk("R9 adapter release", 5'b10001);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule